// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps time for a processor core. It holds a 64-bit free-running time base, kept as a lower and an upper 32-bit word, and a 32-bit decrementer. The decrementer can reload itself from a write-only reload register. All three counters advance together on a timer tick. A control register turns the tick on or off and picks its source. The source is either an internal divide-by-eight of the bus clock or the rising edges of an external timer clock, which is synchronised and sampled at the bus rate.

Each tick spreads its work over three bus cycles. The decrementer moves first, the lower word on the next cycle, and the upper word on the cycle after that. The upper word moves only when the lower word has just wrapped. When the decrementer steps from one to zero, a sticky flag is raised and driven out as the interrupt status. A watchdog-reset code is captured from an event input, held in the status register and mirrored on a 2-bit output. The block never resets anything itself.

Software reaches the registers through a plain write port and a separate combinational read port. This is control access, not a data stream, so there is no valid/ready pair and no back-pressure. A write lands on the clock edge at which it is presented. A read returns the addressed value in the same cycle.

Top module: `tbd_unit`

## Requirements
- R1: After reset, both time base words, the decrementer, the reload value, the control register (bit 0 enable, bit 1 external-source select, bit 2 auto-reload) and the status register all read 0, `dec_irq` is 0 and `wrs` is 0. The reset source selection is therefore the divide-by-eight tick with counting off.
- R2: While control bit 0 is 0, the decrementer and both time base words keep their values.
- R3: With bit 0 set and bit 1 clear, one tick occurs every 8 bus clocks. The first decrementer update lands on the 8th rising edge after the edge that writes the enable.
- R4: With bits 0 and 1 set, a rising edge on `ext_tclk` passes through a two-flop synchroniser. The decrementer update lands on the third bus-clock edge that sees the input high. An input that is held high gives only one tick.
- R5: On a tick the decrementer updates on edge N, the lower word increments on edge N+1, and the upper word updates on edge N+2.
- R6: The upper word increments only when the lower word wrapped from all-ones to zero in the same tick sequence.
- R7: A decrementer step from 1 to 0 sets status bit 0, which drives `dec_irq`. The bit is sticky. With auto-reload off, later ticks leave the decrementer at 0.
- R8: With control bit 2 set, the update that would take the decrementer from 1 to 0 loads the reload value instead, and it still sets status bit 0.
- R9: The read addresses are: 0 lower word, 1 upper word, 2 decrementer, 3 reload register, 4 control, 5 status, 6 the full time base as {upper, lower}. The reload register reads as 0. A 32-bit register sits in the low half of `rd_data` with the upper 32 bits zero, and address 7 reads 0.
- R10: A software write to a counter in the same cycle as its tick update wins. The written value is stored with no increment or decrement applied.
- R11: `wd_evt` loads `wd_kind` into status bits 5:4, which drive `wrs`. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tclk | input | 1 | External timer clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Combinational read data |
| wd_evt | input | 1 | Watchdog reset event pulse |
| wd_kind | input | 2 | Watchdog reset code captured on `wd_evt` |
| dec_irq | output | 1 | Sticky decrementer status |
| wrs | output | 2 | Watchdog reset status field |

## Verification
A register write is visible one edge after it is presented. The first decrementer step after an enable write lands 8 edges later, the lower word follows one edge after that and the upper word two edges after. With the external source, the step follows on the third edge that samples the input high. The bench drives inputs and samples only at falling edges, so it counts exact rising edges from each write. It queues an expected value for every read. Some reads are placed one edge before an update is due, to show that nothing moved early, and the rest are placed on the edge where each update lands.

// File: rtl/tbd_pkg.sv
`timescale 1ns/1ps
package tbd_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TBL  = 3'd0,
    A_TBU  = 3'd1,
    A_DEC  = 3'd2,
    A_RLD  = 3'd3,
    A_CTRL = 3'd4,
    A_STAT = 3'd5,
    A_TB64 = 3'd6
  } reg_addr_e;

  localparam int CTRL_W    = 3;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_SEL  = 1;
  localparam int CTRL_ARLD = 2;

  localparam int ST_DEC    = 0;
  localparam int ST_WRS_LO = 4;
endpackage

// File: rtl/tbd_tick_src.sv
`timescale 1ns/1ps
module tbd_tick_src #(
  parameter int DIV_LOG2 = 3,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel,
  input  logic ext_clk,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;
  // sync_q[SYNC_N-1] is the synchronised level, sync_q[SYNC_N] its delayed copy
  logic [SYNC_N:0]     sync_q;
  logic                ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n)           div_q <= '0;
    else if (en && !sel)  div_q <= div_q + 1'b1;
    else                  div_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], ext_clk};
  end

  assign ext_rise = sync_q[SYNC_N-1] && !sync_q[SYNC_N];
  assign tick     = en && (sel ? ext_rise : (&div_q));
endmodule

// File: rtl/tbd_decrementer.sv
`timescale 1ns/1ps
module tbd_decrementer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic         arld,
  input  logic         wr_dec,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dec,
  output logic         hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] dec_q, rld_q;

  assign hit = upd && !wr_dec && (dec_q == ONE);
  assign dec = dec_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      rld_q <= '0;
    else if (wr_rld) rld_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     dec_q <= '0;
    else if (wr_dec)                dec_q <= wdata;
    else if (hit)                   dec_q <= arld ? rld_q : '0;
    else if (upd && dec_q != '0)    dec_q <= dec_q - ONE;
  end
endmodule

// File: rtl/tbd_timebase.sv
`timescale 1ns/1ps
module tbd_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic         st_lo_q, st_hi_q, carry_q;
  logic [W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_lo_q <= 1'b0;
      st_hi_q <= 1'b0;
    end else begin
      st_lo_q <= tick;
      st_hi_q <= st_lo_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      carry_q <= 1'b0;
    end else if (wr_lo) begin
      lo_q    <= wdata;
      carry_q <= 1'b0;
    end else if (st_lo_q) begin
      lo_q    <= lo_q + 1'b1;
      carry_q <= &lo_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   hi_q <= '0;
    else if (wr_hi)               hi_q <= wdata;
    else if (st_hi_q && carry_q)  hi_q <= hi_q + 1'b1;
  end

  assign lo = lo_q;
  assign hi = hi_q;
endmodule

// File: rtl/tbd_unit.sv
`timescale 1ns/1ps
module tbd_unit
  import tbd_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int DIV_LOG2 = 3,
  parameter int SYNC_N   = 2,
  parameter int WRS_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_tclk,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [2*WORD_W-1:0] rd_data,
  input  logic                wd_evt,
  input  logic [WRS_W-1:0]    wd_kind,
  output logic                dec_irq,
  output logic [WRS_W-1:0]    wrs
);
  localparam int RD_W = 2 * WORD_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q;
  logic [WRS_W-1:0]  wrs_q;
  logic              tick, hit;
  logic [WORD_W-1:0] dec_val, tbl_val, tbu_val;
  logic              wr_tbl, wr_tbu, wr_dec, wr_rld, wr_ctrl, wr_stat;

  assign wr_tbl  = wr_en && (wr_addr == A_TBL);
  assign wr_tbu  = wr_en && (wr_addr == A_TBU);
  assign wr_dec  = wr_en && (wr_addr == A_DEC);
  assign wr_rld  = wr_en && (wr_addr == A_RLD);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  // status: event sets win over a write-one-to-clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wrs_q  <= '0;
    end else begin
      if (hit)          flag_q <= 1'b1;
      else if (wr_stat && wr_data[ST_DEC]) flag_q <= 1'b0;
      if (wd_evt)       wrs_q <= wd_kind;
      else if (wr_stat) wrs_q <= wrs_q & ~wr_data[ST_WRS_LO +: WRS_W];
    end
  end

  tbd_tick_src #(.DIV_LOG2(DIV_LOG2), .SYNC_N(SYNC_N)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl_q[CTRL_EN]), .sel(ctrl_q[CTRL_SEL]),
    .ext_clk(ext_tclk), .tick(tick)
  );

  tbd_decrementer #(.W(WORD_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .upd(tick), .arld(ctrl_q[CTRL_ARLD]),
    .wr_dec(wr_dec), .wr_rld(wr_rld), .wdata(wr_data),
    .dec(dec_val), .hit(hit)
  );

  tbd_timebase #(.W(WORD_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_lo(wr_tbl), .wr_hi(wr_tbu), .wdata(wr_data),
    .lo(tbl_val), .hi(tbu_val)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TBL:   rd_data[WORD_W-1:0] = tbl_val;
      A_TBU:   rd_data[WORD_W-1:0] = tbu_val;
      A_DEC:   rd_data[WORD_W-1:0] = dec_val;
      A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      A_STAT: begin
        rd_data[ST_DEC]              = flag_q;
        rd_data[ST_WRS_LO +: WRS_W]  = wrs_q;
      end
      A_TB64:  rd_data = {tbu_val, tbl_val};
      default: rd_data = '0;
    endcase
  end

  assign dec_irq = flag_q;
  assign wrs     = wrs_q;
endmodule

// File: rtl/tbd_checker.sv
`timescale 1ns/1ps
module tbd_checker
  import tbd_pkg::*;
#(
  parameter int W     = 32,
  parameter int WRS_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic              wd_evt,
  input logic [WRS_W-1:0]  wd_kind,
  input logic [WRS_W-1:0]  wrs,
  input logic              dec_irq,
  input logic [CTRL_W-1:0] ctrl,
  input logic [W-1:0]      dec,
  input logic [W-1:0]      tbl,
  input logic [W-1:0]      tbu
);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DEC) |=> (dec == $past(wr_data)));

  a_r7_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_irq && !(wr_en && wr_addr == A_STAT && wr_data[ST_DEC])) |=> dec_irq);

  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dec == '0 && !ctrl[CTRL_ARLD] && !(wr_en && wr_addr == A_DEC)) |=> (dec == '0));

  a_r6_hi_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((tbu != $past(tbu)) && !$past(wr_en && wr_addr == A_TBU)) |-> ($past(tbl) == '0));

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CTRL_EN] && $past(!ctrl[CTRL_EN]) && $past(!ctrl[CTRL_EN], 2) && !wr_en)
      |=> ($stable(dec) && $stable(tbl) && $stable(tbu)));

  a_r11_wrs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wd_evt |=> (wrs == $past(wd_kind)));
endmodule

bind tbd_unit tbd_checker #(.W(WORD_W), .WRS_W(WRS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wd_evt(wd_evt), .wd_kind(wd_kind), .wrs(wrs), .dec_irq(dec_irq),
  .ctrl(ctrl_q), .dec(dec_val), .tbl(tbl_val), .tbu(tbu_val)
);

// File: tb/tb_tbd_unit.sv
`timescale 1ns/1ps
module tb_tbd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tclk = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        wd_evt = 1'b0;
  logic [1:0]  wd_kind = '0;
  logic        dec_irq;
  logic [1:0]  wrs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  bit          pin_q[$];
  string       tag_q[$];
  event        go;

  always #2 clk = ~clk;

  tbd_unit dut (
    .clk(clk), .rst_n(rst_n), .ext_tclk(ext_tclk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wd_evt(wd_evt), .wd_kind(wd_kind), .dec_irq(dec_irq), .wrs(wrs)
  );

  // monitor: pops one expected item per observation
  initial forever begin
    logic [63:0] act, e;
    bit p;
    string t;
    @(go);
    e = exp_q.pop_front();
    p = pin_q.pop_front();
    t = tag_q.pop_front();
    act = p ? {61'd0, dec_irq, wrs} : rd_data;
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [63:0] e, input string t);
    exp_q.push_back(e); pin_q.push_back(1'b0); tag_q.push_back(t);
    rd_addr = a;
    #0.1;
    -> go;
    #0.1;
  endtask

  task automatic chk_pin(input logic [63:0] e, input string t);
    exp_q.push_back(e); pin_q.push_back(1'b1); tag_q.push_back(t);
    #0.1;
    -> go;
    #0.1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    adv(4);
    rst_n = 1'b1;
    adv(1);
    // R1 reset state
    chk_rd(0, 64'd0, "R1 tbl");
    chk_rd(1, 64'd0, "R1 tbu");
    chk_rd(2, 64'd0, "R1 dec");
    chk_rd(4, 64'd0, "R1 ctrl");
    chk_rd(5, 64'd0, "R1 status");
    chk_pin(64'd0, "R1 pins");

    // R9 register map
    wr(0, 32'hFFFF_FFFE);
    wr(1, 32'd5);
    wr(2, 32'd3);
    wr(3, 32'h40);
    chk_rd(3, 64'd0, "R9 reload reads zero");
    chk_rd(6, 64'h0000_0005_FFFF_FFFE, "R9 full time base");
    chk_rd(2, 64'd3, "R9 dec low half");
    chk_rd(7, 64'd0, "R9 unused address");

    // R2 disabled holds
    adv(20);
    chk_rd(0, 64'hFFFF_FFFE, "R2 tbl held");
    chk_rd(2, 64'd3, "R2 dec held");

    // R3/R5/R6 divide-by-eight sequence
    wr(4, 32'd1);
    adv(7);
    chk_rd(2, 64'd3, "R3 no early tick");
    adv(1);
    chk_rd(2, 64'd2, "R3 dec at edge 8");
    chk_rd(0, 64'hFFFF_FFFE, "R5 tbl not yet");
    adv(1);
    chk_rd(0, 64'hFFFF_FFFF, "R5 tbl at edge 9");
    adv(1);
    chk_rd(1, 64'd5, "R6 no carry");
    adv(6);
    chk_rd(2, 64'd1, "R3 dec at edge 16");
    adv(1);
    chk_rd(0, 64'd0, "R6 tbl wraps");
    chk_rd(1, 64'd5, "R5 tbu not yet");
    adv(1);
    chk_rd(1, 64'd6, "R6 tbu after wrap");
    adv(6);
    chk_rd(2, 64'd0, "R7 dec reaches zero");
    chk_pin(64'd4, "R7 flag set");
    adv(1);
    chk_rd(0, 64'd1, "R5 tbl step");
    adv(7);
    chk_rd(2, 64'd0, "R7 dec stays zero");
    adv(1);
    chk_rd(0, 64'd2, "R3 fourth tick");

    // R10 write priority over tick updates
    adv(6);
    wr(2, 32'd100);
    chk_rd(2, 64'd100, "R10 dec write wins");
    wr(0, 32'h10);
    chk_rd(0, 64'h10, "R10 tbl write wins");
    chk_rd(1, 64'd6, "R10 tbu untouched");

    // R2 disable
    wr(4, 32'd0);
    adv(20);
    chk_rd(2, 64'd100, "R2 dec frozen");
    chk_rd(0, 64'h10, "R2 tbl frozen");

    // R11 write-one-to-clear
    wr(5, 32'd0);
    chk_pin(64'd4, "R11 write zero keeps flag");
    wr(5, 32'd1);
    chk_pin(64'd0, "R11 flag cleared");
    chk_rd(5, 64'd0, "R11 status zero");

    // R8 auto-reload
    wr(3, 32'd7);
    wr(2, 32'd1);
    wr(4, 32'd5);
    adv(8);
    chk_rd(2, 64'd7, "R8 reload on 1 to 0");
    chk_pin(64'd4, "R8 flag set on reload");
    adv(8);
    chk_rd(2, 64'd6, "R8 counts after reload");

    // R4 external clock
    wr(4, 32'd3);
    adv(3);
    chk_rd(2, 64'd6, "R4 before edge");
    ext_tclk = 1'b1;
    adv(2);
    chk_rd(2, 64'd6, "R4 not at second edge");
    adv(1);
    chk_rd(2, 64'd5, "R4 third edge");
    adv(6);
    chk_rd(2, 64'd5, "R4 held high one tick");
    ext_tclk = 1'b0;
    adv(4);
    ext_tclk = 1'b1;
    adv(2);
    chk_rd(2, 64'd5, "R4 second pulse early");
    adv(1);
    chk_rd(2, 64'd4, "R4 second pulse");

    // R11 watchdog status
    wd_evt = 1'b1; wd_kind = 2'd2;
    adv(1);
    wd_evt = 1'b0;
    chk_pin(64'd6, "R11 wrs captured");
    chk_rd(5, 64'h21, "R11 status fields");
    wr(5, 32'h30);
    chk_rd(5, 64'h01, "R11 wrs cleared");
    chk_pin(64'd4, "R11 pins after clear");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule